// File: doc/BRIEF.md
# Coprocessor Instruction Arbiter with Exchange Registers

This block sits between instruction fetch and a general-purpose core. Each incoming word is either passed through untouched to the core or, when it carries the coprocessor major opcode, decoded and handled locally. Configuration and execution commands for a reconfigurable unit go out on a command port. Register moves are served from a 512-entry exchange register file. Join instructions are absorbed once all outstanding work has finished.

Execution commands are tracked in a small table of in-flight slots. Each new execution takes the lowest free slot. When the command is accepted, the exchange register whose index equals the slot number is read. Its low nine bits become the base of that operation's parameter window. Several independent executions may be in flight at once. A read-back from a register inside a busy window waits for that slot's completion. A join instruction waits for every slot to drain.

Top module: `rca_arbiter`

## Requirements
- R1: A word whose bits [31:26] differ from 6'h3B is accepted in the same cycle it is presented and appears unchanged on `core_instr` with `core_valid` high exactly one cycle after acceptance.
- R2: Coprocessor subfunction bits [25:23] values 0, 1, 4 and 5 (configure, execute, configure-prefetch, execute-prefetch) produce `cmd_valid` one cycle after acceptance, with `cmd_kind` 0, 1, 2, 3 respectively and `cmd_addr` equal to bits [22:0]; they are only accepted while `cop_ready` is high.
- R3: Subfunction 2 writes exchange register bits [22:14] with `core_rd_data`, where `core_rd_idx` presents bits [4:0]; it is never stalled.
- R4: Subfunction 3 produces `mfx_valid` one cycle after acceptance, with `mfx_reg` equal to bits [4:0] and `mfx_data` equal to the exchange register selected by bits [22:14].
- R5: An execute command takes the lowest-numbered free slot of NSLOT and reports it on `cmd_tag` (0 for the other command kinds). The slot stays busy until `cop_done` with that tag. With every slot busy, an execute stalls.
- R6: When an execute is accepted, its slot's window base is the low 9 bits of exchange register number equal to the slot. A subfunction-3 read whose index lies in [base, base+PAR_WIN) of a busy slot stalls until that slot completes. Reads outside every busy window proceed.
- R7: Subfunctions 6 and 7 (join) stall while any slot is busy. Once accepted they drive no output port.
- R8: Two execute commands may be accepted on consecutive cycles without any completion in between.
- R9: After reset no output valid is high, all slots are free and a non-coprocessor word is accepted.
- R10: The coprocessor write port updates the exchange register file. When it targets the same index as a subfunction-2 write in the same cycle, the subfunction-2 value is kept.
- R11: `cop_rd_data` combinationally returns the exchange register selected by `cop_rd_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word present |
| in_instr | input | 32 | Instruction word from fetch |
| in_ready | output | 1 | Word is accepted this cycle if valid |
| core_valid | output | 1 | Forwarded word valid |
| core_instr | output | 32 | Forwarded word |
| core_rd_idx | output | 5 | Core register read index for register-to-exchange moves |
| core_rd_data | input | 32 | Core register value for that index |
| mfx_valid | output | 1 | Exchange-to-core move result valid |
| mfx_reg | output | 5 | Destination core register |
| mfx_data | output | 32 | Value read from the exchange file |
| cmd_valid | output | 1 | Coprocessor command valid |
| cmd_kind | output | 2 | 0 configure, 1 execute, 2 configure-prefetch, 3 execute-prefetch |
| cmd_tag | output | 2 | Slot of an execute command |
| cmd_addr | output | 23 | Microcode address |
| cop_ready | input | 1 | Coprocessor can take a command |
| cop_done | input | 1 | Completion pulse |
| cop_done_tag | input | 2 | Slot that completed |
| cop_wr_en | input | 1 | Coprocessor exchange register write |
| cop_wr_idx | input | 9 | Write index |
| cop_wr_data | input | 32 | Write data |
| cop_rd_idx | input | 9 | Coprocessor read index |
| cop_rd_data | output | 32 | Coprocessor read data |

## Verification
The bound checker watches, on every cycle, the one-cycle forwarding of core words and the fact that core words never stall. It also checks that the three output valids are mutually exclusive, that a command only leaves after `cop_ready` was seen, that a read-back result only follows an accepted read-back, and that an accepted join is silent. Slot choice, window-base capture, read-back stalls that depend on which slot is busy, release on completion, and the write collision rule depend on register contents and history. Only the bench scenarios show these, by comparing every output against a queue of expected items.

// File: rtl/rca_pkg.sv
package rca_pkg;

    localparam int WORD_W   = 32;
    localparam int XIDX_W   = 9;
    localparam int CREG_W   = 5;
    localparam int ADDR_W   = 23;
    localparam logic [5:0] COP_MAJOR = 6'h3B;

    typedef enum logic [2:0] {
        SF_CONFIG   = 3'd0,
        SF_RUN      = 3'd1,
        SF_TO_X     = 3'd2,
        SF_FROM_X   = 3'd3,
        SF_CONFIG_P = 3'd4,
        SF_RUN_P    = 3'd5,
        SF_JOIN_A   = 3'd6,
        SF_JOIN_B   = 3'd7
    } subfn_e;

    typedef enum logic [1:0] {
        CK_CONFIG   = 2'd0,
        CK_RUN      = 2'd1,
        CK_CONFIG_P = 2'd2,
        CK_RUN_P    = 2'd3
    } cmd_kind_e;

    typedef enum logic [2:0] {
        CL_CORE,
        CL_CMD,
        CL_TO_X,
        CL_FROM_X,
        CL_JOIN
    } op_class_e;

    typedef struct packed {
        op_class_e          cls;
        cmd_kind_e          kind;
        logic [ADDR_W-1:0]  addr;
        logic [XIDX_W-1:0]  xidx;
        logic [CREG_W-1:0]  creg;
    } dec_t;

    function automatic dec_t decode_word(input logic [WORD_W-1:0] w);
        dec_t d;
        subfn_e sf;
        sf     = subfn_e'(w[25:23]);
        d.addr = w[22:0];
        d.xidx = w[22:14];
        d.creg = w[4:0];
        d.kind = CK_CONFIG;
        d.cls  = CL_CORE;
        if (w[31:26] == COP_MAJOR) begin
            unique case (sf)
                SF_CONFIG:   begin d.cls = CL_CMD; d.kind = CK_CONFIG;   end
                SF_RUN:      begin d.cls = CL_CMD; d.kind = CK_RUN;      end
                SF_CONFIG_P: begin d.cls = CL_CMD; d.kind = CK_CONFIG_P; end
                SF_RUN_P:    begin d.cls = CL_CMD; d.kind = CK_RUN_P;    end
                SF_TO_X:     d.cls = CL_TO_X;
                SF_FROM_X:   d.cls = CL_FROM_X;
                default:     d.cls = CL_JOIN;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/rca_decode.sv
module rca_decode
    import rca_pkg::*;
(
    input  logic [WORD_W-1:0] instr,
    output dec_t              dec
);
    always_comb dec = decode_word(instr);
endmodule

// File: rtl/rca_xreg_file.sv
module rca_xreg_file
    import rca_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input  logic              clk,
    input  logic              mt_en,
    input  logic [XIDX_W-1:0] mt_idx,
    input  logic [WORD_W-1:0] mt_data,
    input  logic              cw_en,
    input  logic [XIDX_W-1:0] cw_idx,
    input  logic [WORD_W-1:0] cw_data,
    input  logic [XIDX_W-1:0] fx_idx,
    output logic [WORD_W-1:0] fx_data,
    input  logic [XIDX_W-1:0] cr_idx,
    output logic [WORD_W-1:0] cr_data,
    input  logic [XIDX_W-1:0] ptr_idx,
    output logic [XIDX_W-1:0] ptr_data
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic              cw_keep;

    assign cw_keep = cw_en && !(mt_en && (mt_idx == cw_idx));

    always_ff @(posedge clk) begin
        if (cw_keep) mem[cw_idx] <= cw_data;
        if (mt_en)   mem[mt_idx] <= mt_data;
    end

    assign fx_data  = mem[fx_idx];
    assign cr_data  = mem[cr_idx];
    assign ptr_data = mem[ptr_idx][XIDX_W-1:0];
endmodule

// File: rtl/rca_slot_table.sv
module rca_slot_table
    import rca_pkg::*;
#(
    parameter int NSLOT   = 4,
    parameter int PAR_WIN = 2,
    parameter int TAG_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_en,
    input  logic [XIDX_W-1:0] alloc_base,
    input  logic              done_en,
    input  logic [TAG_W-1:0]  done_tag,
    input  logic [XIDX_W-1:0] query_idx,
    output logic              free_any,
    output logic [TAG_W-1:0]  alloc_tag,
    output logic              any_busy,
    output logic              hazard
);
    localparam int CMP_W = XIDX_W + 1;

    logic [NSLOT-1:0]  busy;
    logic [XIDX_W-1:0] base [NSLOT];
    logic [NSLOT-1:0]  hit;

    always_comb begin
        alloc_tag = '0;
        free_any  = 1'b0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                alloc_tag = TAG_W'(i);
                free_any  = 1'b1;
            end
        end
    end

    generate
        for (genvar g = 0; g < NSLOT; g++) begin : g_slot
            logic [CMP_W-1:0] lo, hi, q;
            assign lo = {1'b0, base[g]};
            assign hi = lo + CMP_W'(PAR_WIN);
            assign q  = {1'b0, query_idx};
            assign hit[g] = busy[g] && (q >= lo) && (q < hi);

            always_ff @(posedge clk) begin
                if (rst) begin
                    busy[g] <= 1'b0;
                    base[g] <= '0;
                end else if (alloc_en && alloc_tag == TAG_W'(g)) begin
                    busy[g] <= 1'b1;
                    base[g] <= alloc_base;
                end else if (done_en && done_tag == TAG_W'(g)) begin
                    busy[g] <= 1'b0;
                end
            end
        end
    endgenerate

    assign any_busy = |busy;
    assign hazard   = |hit;
endmodule

// File: rtl/rca_arbiter.sv
module rca_arbiter
    import rca_pkg::*;
#(
    parameter int NSLOT    = 4,
    parameter int PAR_WIN  = 2,
    parameter int XR_DEPTH = 512,
    localparam int TAG_W   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [31:0]       in_instr,
    output logic              in_ready,
    output logic              core_valid,
    output logic [31:0]       core_instr,
    output logic [4:0]        core_rd_idx,
    input  logic [31:0]       core_rd_data,
    output logic              mfx_valid,
    output logic [4:0]        mfx_reg,
    output logic [31:0]       mfx_data,
    output logic              cmd_valid,
    output logic [1:0]        cmd_kind,
    output logic [TAG_W-1:0]  cmd_tag,
    output logic [22:0]       cmd_addr,
    input  logic              cop_ready,
    input  logic              cop_done,
    input  logic [TAG_W-1:0]  cop_done_tag,
    input  logic              cop_wr_en,
    input  logic [8:0]        cop_wr_idx,
    input  logic [31:0]       cop_wr_data,
    input  logic [8:0]        cop_rd_idx,
    output logic [31:0]       cop_rd_data
);
    dec_t              dec;
    logic              fire;
    logic              alloc_en;
    logic              free_any;
    logic              any_busy;
    logic              hazard;
    logic [TAG_W-1:0]  alloc_tag;
    logic [XIDX_W-1:0] ptr_base;
    logic [WORD_W-1:0] fx_word;

    rca_decode u_dec (
        .instr (in_instr),
        .dec   (dec)
    );

    rca_xreg_file #(.DEPTH(XR_DEPTH)) u_xr (
        .clk      (clk),
        .mt_en    (fire && dec.cls == CL_TO_X),
        .mt_idx   (dec.xidx),
        .mt_data  (core_rd_data),
        .cw_en    (cop_wr_en),
        .cw_idx   (cop_wr_idx),
        .cw_data  (cop_wr_data),
        .fx_idx   (dec.xidx),
        .fx_data  (fx_word),
        .cr_idx   (cop_rd_idx),
        .cr_data  (cop_rd_data),
        .ptr_idx  (XIDX_W'(alloc_tag)),
        .ptr_data (ptr_base)
    );

    rca_slot_table #(.NSLOT(NSLOT), .PAR_WIN(PAR_WIN), .TAG_W(TAG_W)) u_slots (
        .clk        (clk),
        .rst        (rst),
        .alloc_en   (alloc_en),
        .alloc_base (ptr_base),
        .done_en    (cop_done),
        .done_tag   (cop_done_tag),
        .query_idx  (dec.xidx),
        .free_any   (free_any),
        .alloc_tag  (alloc_tag),
        .any_busy   (any_busy),
        .hazard     (hazard)
    );

    always_comb begin
        unique case (dec.cls)
            CL_CMD:    in_ready = cop_ready && (dec.kind != CK_RUN || free_any);
            CL_FROM_X: in_ready = !hazard;
            CL_JOIN:   in_ready = !any_busy;
            default:   in_ready = 1'b1;
        endcase
    end

    assign fire        = in_valid && in_ready;
    assign alloc_en    = fire && dec.cls == CL_CMD && dec.kind == CK_RUN;
    assign core_rd_idx = dec.creg;

    always_ff @(posedge clk) begin
        if (rst) begin
            core_valid <= 1'b0;
            cmd_valid  <= 1'b0;
            mfx_valid  <= 1'b0;
            core_instr <= '0;
            cmd_kind   <= '0;
            cmd_tag    <= '0;
            cmd_addr   <= '0;
            mfx_reg    <= '0;
            mfx_data   <= '0;
        end else begin
            core_valid <= fire && dec.cls == CL_CORE;
            cmd_valid  <= fire && dec.cls == CL_CMD;
            mfx_valid  <= fire && dec.cls == CL_FROM_X;
            if (fire && dec.cls == CL_CORE) core_instr <= in_instr;
            if (fire && dec.cls == CL_CMD) begin
                cmd_kind <= dec.kind;
                cmd_addr <= dec.addr;
                cmd_tag  <= (dec.kind == CK_RUN) ? alloc_tag : '0;
            end
            if (fire && dec.cls == CL_FROM_X) begin
                mfx_reg  <= dec.creg;
                mfx_data <= fx_word;
            end
        end
    end
endmodule

// File: rtl/rca_arbiter_chk.sv
module rca_arbiter_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] in_instr,
    input logic        in_ready,
    input logic        core_valid,
    input logic [31:0] core_instr,
    input logic        mfx_valid,
    input logic        cmd_valid,
    input logic        cop_ready
);
    logic is_cop, is_fromx, is_join, take;
    assign is_cop   = in_instr[31:26] == 6'h3B;
    assign is_fromx = is_cop && in_instr[25:23] == 3'd3;
    assign is_join  = is_cop && in_instr[25:24] == 2'b11;
    assign take     = in_valid && in_ready;

    AST_CORE_NEVER_STALLS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !is_cop) |-> in_ready);                                   // R1
    AST_CORE_FORWARD: assert property (@(posedge clk) disable iff (rst)
        (take && !is_cop) |=> (core_valid && core_instr == $past(in_instr)));  // R1
    AST_CMD_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(cop_ready));                                       // R2
    AST_FROMX_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        mfx_valid |-> $past(take && is_fromx));                                // R4
    AST_JOIN_SILENT: assert property (@(posedge clk) disable iff (rst)
        (take && is_join) |=> !(core_valid || cmd_valid || mfx_valid));        // R7
    AST_ONE_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({core_valid, cmd_valid, mfx_valid}));                         // R7
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !(core_valid || cmd_valid || mfx_valid));               // R9
endmodule

bind rca_arbiter rca_arbiter_chk u_chk (.*);

// File: tb/rca_arbiter_bench.sv
module rca_arbiter_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic        in_ready;
    logic        core_valid;
    logic [31:0] core_instr;
    logic [4:0]  core_rd_idx;
    logic [31:0] core_rd_data;
    logic        mfx_valid;
    logic [4:0]  mfx_reg;
    logic [31:0] mfx_data;
    logic        cmd_valid;
    logic [1:0]  cmd_kind;
    logic [1:0]  cmd_tag;
    logic [22:0] cmd_addr;
    logic        cop_ready = 1'b1;
    logic        cop_done = 1'b0;
    logic [1:0]  cop_done_tag = '0;
    logic        cop_wr_en = 1'b0;
    logic [8:0]  cop_wr_idx = '0;
    logic [31:0] cop_wr_data = '0;
    logic [8:0]  cop_rd_idx = '0;
    logic [31:0] cop_rd_data;

    int vectors = 0;
    int errors  = 0;

    always #10 clk = ~clk;

    // core register r holds the value r
    assign core_rd_data = {27'b0, core_rd_idx};

    rca_arbiter u_rca_arbiter (.*);

    typedef struct {
        int          typ;   // 0 core, 1 cmd, 2 read-back
        logic [63:0] val;
        string       req;
    } exp_t;
    exp_t exp_q[$];

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic expect_item(input int typ, input logic [63:0] val, input string req);
        exp_t e;
        e.typ = typ; e.val = val; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic take_out(input int typ, input logic [63:0] val);
        exp_t e;
        if (exp_q.size() == 0) begin
            vectors++; errors++;
            $display("FAIL unexpected output type %0d actual=%h expected=none", typ, val);
        end else begin
            e = exp_q.pop_front();
            chk(e.req, {val[61:0], 2'(typ)}, {e.val[61:0], 2'(e.typ)});
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (core_valid) take_out(0, 64'(core_instr));
            if (cmd_valid)  take_out(1, 64'({cmd_kind, cmd_tag, cmd_addr}));
            if (mfx_valid)  take_out(2, 64'({mfx_reg, mfx_data}));
        end
    end

    function automatic logic [31:0] mv(input logic [2:0] sf, input logic [8:0] x, input logic [4:0] r);
        return {6'h3B, sf, x, 9'b0, r};
    endfunction
    function automatic logic [31:0] cm(input logic [2:0] sf, input logic [22:0] a);
        return {6'h3B, sf, a};
    endfunction

    task automatic present(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_instr = w;
        #1;
    endtask
    task automatic complete;
        while (!in_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask
    task automatic issue(input logic [31:0] w);
        present(w);
        complete();
    endtask
    task automatic done_pulse(input logic [1:0] t);
        @(negedge clk);
        cop_done = 1'b1; cop_done_tag = t;
        @(negedge clk);
        cop_done = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk); #1;
        chk("R9 idle ready", 64'(in_ready), 64'd1);
        chk("R9 quiet outputs", 64'({core_valid, cmd_valid, mfx_valid}), 64'd0);

        // R1 forwarding, several patterns including neighbouring opcode
        expect_item(0, 64'h0000_0000_1234_5678, "R1 plain");
        issue(32'h1234_5678);
        expect_item(0, 64'h0000_0000_E800_0001, "R1 near opcode");
        issue(32'hE800_0001);
        expect_item(0, 64'h0000_0000_FFFF_FFFF, "R1 all ones");
        issue(32'hFFFF_FFFF);

        // R3 fill pointers and parameters
        issue(mv(3'd2, 9'd0, 5'd2));
        issue(mv(3'd2, 9'd1, 5'd4));
        issue(mv(3'd2, 9'd5, 5'd9));
        issue(mv(3'd2, 9'd6, 5'd7));
        expect_item(2, 64'({5'd1, 32'd9}), "R3 R4 read-back");
        issue(mv(3'd3, 9'd5, 5'd1));

        // R2 command kinds
        expect_item(1, 64'({2'd0, 2'd0, 23'h001234}), "R2 configure");
        issue(cm(3'd0, 23'h001234));
        expect_item(1, 64'({2'd2, 2'd0, 23'h7FFFFF}), "R2 configure prefetch");
        issue(cm(3'd4, 23'h7FFFFF));
        expect_item(1, 64'({2'd3, 2'd0, 23'h000010}), "R2 execute prefetch");
        issue(cm(3'd5, 23'h000010));

        // R5 R8 back-to-back executes, slots 0 and 1
        expect_item(1, 64'({2'd1, 2'd0, 23'h000100}), "R5 R8 first execute");
        issue(cm(3'd1, 23'h000100));
        expect_item(1, 64'({2'd1, 2'd1, 23'h000200}), "R5 R8 second execute");
        issue(cm(3'd1, 23'h000200));

        // R6 read-back inside slot 0 window [2,3] stalls
        present(mv(3'd3, 9'd3, 5'd11));
        chk("R6 stall in window", 64'(in_ready), 64'd0);
        cop_wr_en = 1'b1; cop_wr_idx = 9'd3; cop_wr_data = 32'h0000_BEEF;
        @(negedge clk); cop_wr_en = 1'b0; #1;
        chk("R6 still stalled", 64'(in_ready), 64'd0);
        cop_done = 1'b1; cop_done_tag = 2'd0;
        @(negedge clk); cop_done = 1'b0; #1;
        chk("R6 released", 64'(in_ready), 64'd1);
        expect_item(2, 64'({5'd11, 32'h0000_BEEF}), "R6 R10 result");
        complete();

        // R6 outside slot 1 window [4,5] proceeds
        present(mv(3'd3, 9'd6, 5'd12));
        chk("R6 outside window", 64'(in_ready), 64'd1);
        expect_item(2, 64'({5'd12, 32'd7}), "R6 outside data");
        complete();

        // R5 fill remaining slots: 0, 2, 3
        expect_item(1, 64'({2'd1, 2'd0, 23'h000300}), "R5 reuse slot 0");
        issue(cm(3'd1, 23'h000300));
        expect_item(1, 64'({2'd1, 2'd2, 23'h000400}), "R5 slot 2");
        issue(cm(3'd1, 23'h000400));
        expect_item(1, 64'({2'd1, 2'd3, 23'h000500}), "R5 slot 3");
        issue(cm(3'd1, 23'h000500));
        present(cm(3'd1, 23'h000600));
        chk("R5 full stall", 64'(in_ready), 64'd0);
        cop_done = 1'b1; cop_done_tag = 2'd2;
        @(negedge clk); cop_done = 1'b0; #1;
        expect_item(1, 64'({2'd1, 2'd2, 23'h000600}), "R5 freed slot 2");
        complete();

        // R7 join waits for all slots
        present(cm(3'd6, 23'h0));
        chk("R7 join stall", 64'(in_ready), 64'd0);
        in_valid = 1'b0;
        for (int t = 0; t < 4; t++) done_pulse(2'(t));
        present(cm(3'd7, 23'h0));
        chk("R7 join accepted", 64'(in_ready), 64'd1);
        complete();
        expect_item(0, 64'h0000_0000_0BAD_F00D, "R7 next after join");
        issue(32'h0BAD_F00D);

        // R10 write collision, R11 coprocessor read
        @(negedge clk);
        in_valid = 1'b1; in_instr = mv(3'd2, 9'd8, 5'd3);
        cop_wr_en = 1'b1; cop_wr_idx = 9'd8; cop_wr_data = 32'h0000_FFFF;
        @(posedge clk); #1;
        in_valid = 1'b0; cop_wr_en = 1'b0;
        expect_item(2, 64'({5'd10, 32'd3}), "R10 collision kept core value");
        issue(mv(3'd3, 9'd8, 5'd10));
        cop_rd_idx = 9'd8; #1;
        chk("R11 read idx 8", 64'(cop_rd_data), 64'd3);
        cop_rd_idx = 9'd3; #1;
        chk("R11 read idx 3", 64'(cop_rd_data), 64'h0000_BEEF);

        // R2 command waits for cop_ready
        cop_ready = 1'b0;
        present(cm(3'd0, 23'h000055));
        chk("R2 not ready stall", 64'(in_ready), 64'd0);
        @(negedge clk); #1;
        chk("R2 still stalled", 64'(in_ready), 64'd0);
        cop_ready = 1'b1; #1;
        expect_item(1, 64'({2'd0, 2'd0, 23'h000055}), "R2 after ready");
        complete();

        repeat (4) @(negedge clk);
        chk("R1 R2 R4 all expected outputs seen", 64'(exp_q.size()), 64'd0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule